// File: doc/BRIEF.md
# Traversal Cache Accelerator Controller

This block is the control unit of an accelerator that works on pointer-based data structures such as lists and trees. When the host first walks a structure, it pushes the words it fetches into the block one at a time. The block hands each word straight to the downstream datapath. It also records the word, in arrival order, into a local sequential memory. On later runs of the same walk, the block plays the recorded words back at one word per cycle, so the host does not need to take part.

Several independent recordings exist, and an identifier chosen by the host picks one of them for each run. The host can discard a recording with an invalidate strobe. A recording is also discarded when it would not fit in its memory, or when it is invalidated while it is still being captured. A separate array mode reads an ordinary local RAM with a base address, a stride and a word count instead of using a recording. The host controls the block through level signals (traversal mode, start, invalidate, identifier) and reads back three status flags: assistance needed, finished and overflow.

Top module: `tcache_ctrl`

## Requirements
- R1: In idle, with `is_trav_i` high, `need_assist_o` is 1 when the recording picked by `trav_id_i` is not valid and 0 when it is valid. `need_assist_o` stays 1 for the whole of an assisted run.
- R2: During an assisted run, a word on the input is passed to the output in the same cycle (`out_valid_o`/`out_data_o` equal `in_valid_i`/`in_data_i`). `in_ready_o` is 1 only while `out_ready_i` and `is_trav_i` are both 1.
- R3: Accepted assisted words are stored at addresses 0, 1, 2 and so on. When `is_trav_i` drops, the run ends. `done_o` reads 1 from the following cycle, and the recording becomes valid with the number of words accepted as its length.
- R4: Asserting `go_i` with `is_trav_i` high on a valid recording replays exactly its stored length, in stored order. With `out_ready_i` held high this takes one word per cycle on consecutive cycles, and `done_o` follows.
- R5: In replay and array mode, a word shown with `out_valid_o` high while `out_ready_i` is low stays unchanged until it is accepted.
- R6: Asserting `go_i` with `is_trav_i` low starts array mode. Word k comes from RAM address (`arr_base_i` + k*`arr_stride_i`) mod RAM_DEPTH, for k = 0 to `arr_len_i`-1. The RAM is written through `ram_we_i`, `ram_waddr_i` and `ram_wdata_i`.
- R7: Pulsing `inval_i` clears the recording picked by `trav_id_i`. The next traversal with that identifier again reports `need_assist_o` = 1.
- R8: Each identifier has its own recording. Capturing into or invalidating one identifier does not change what another identifier replays or whether it is valid.
- R9: An assisted stream longer than DEPTH words still passes every word to the output. It sets `overflow_o`, and the recording is left invalid.
- R10: An invalidate aimed at the identifier being captured, arriving during the assisted run, leaves that recording invalid after the run ends.
- R11: `done_o` stays high until the next accepted `go_i`. An array run with a length of 0, or a replay of a length-0 recording, raises `done_o` one cycle after `go_i` and outputs no words.
- R12: After reset all recordings are invalid, and `done_o`, `overflow_o`, `out_valid_o` and `in_ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_trav_i | input | 1 | Host: this run is a pointer traversal; dropping it ends an assisted stream |
| go_i | input | 1 | Host: start a run (taken only in idle) |
| inval_i | input | 1 | Host: discard the recording picked by `trav_id_i` |
| trav_id_i | input | $clog2(NUM_CACHES) | Host: recording selector |
| need_assist_o | output | 1 | Host must supply the stream |
| done_o | output | 1 | Run finished (sticky until next `go_i`) |
| overflow_o | output | 1 | Last assisted stream did not fit |
| ram_we_i | input | 1 | Array RAM write enable |
| ram_waddr_i | input | $clog2(RAM_DEPTH) | Array RAM write address |
| ram_wdata_i | input | DW | Array RAM write data |
| arr_base_i | input | $clog2(RAM_DEPTH) | Array mode start address |
| arr_stride_i | input | $clog2(RAM_DEPTH) | Array mode address step |
| arr_len_i | input | $clog2(RAM_DEPTH+1) | Array mode word count |
| in_valid_i | input | 1 | Assisted word valid |
| in_ready_o | output | 1 | Assisted word accepted |
| in_data_i | input | DW | Assisted word |
| out_valid_o | output | 1 | Datapath word valid |
| out_ready_i | input | 1 | Datapath can take a word |
| out_data_o | output | DW | Datapath word |

## Verification
The assertions assume that the host leaves the array RAM unwritten during an array run, so a stalled word cannot change underneath the output. They also assume that `go_i` is raised only in idle, and that `is_trav_i` is held high from `go_i` until the last assisted word has been accepted. The stimulus writes the RAM only before array runs. It raises `go_i` for a single cycle from idle, and it drops `is_trav_i` only after the last word has been taken. Random input gaps and random output stalls then exercise the handshakes without leaving these limits.

// File: rtl/tcache_pkg.sv
package tcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ASSIST = 2'd1,
    ST_REPLAY = 2'd2,
    ST_ARRAY  = 2'd3
  } tc_state_e;
endpackage

// File: rtl/tcache_store.sv
module tcache_store #(
  parameter int N     = 4,
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IW-1:0]         wr_id_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic                  commit_i,
  input  logic [IW-1:0]         commit_id_i,
  input  logic [LW-1:0]         commit_len_i,
  input  logic                  inv_i,
  input  logic [IW-1:0]         inv_id_i,
  input  logic [IW-1:0]         rd_id_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [DW-1:0]         rd_data_o,
  output logic [N-1:0]          valid_o,
  output logic [N-1:0][LW-1:0]  len_o
);

  logic [N-1:0][DW-1:0] rd_word;

  for (genvar g = 0; g < N; g++) begin : g_way
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_id_i == IW'(g)) mem[wr_addr_i] <= wr_data_i;
    end

    assign rd_word[g] = mem[rd_addr_i];

    // invalidate wins over a commit to the same way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        len_o[g]   <= '0;
      end else if (inv_i && inv_id_i == IW'(g)) begin
        valid_o[g] <= 1'b0;
      end else if (commit_i && commit_id_i == IW'(g)) begin
        valid_o[g] <= 1'b1;
        len_o[g]   <= commit_len_i;
      end
    end
  end

  assign rd_data_o = rd_word[rd_id_i];

  p_inval_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !valid_o[$past(inv_id_i)]);

  p_commit_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !(inv_i && inv_id_i == commit_id_i))
    |=> (valid_o[$past(commit_id_i)] && len_o[$past(commit_id_i)] == $past(commit_len_i)));

endmodule

// File: rtl/tcache_array.sv
module tcache_array #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic          step_i,
  output logic [DW-1:0] rd_data_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic [AW-1:0] stride_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // address wraps modulo DEPTH (power of two)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (start_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
    end else if (step_i) begin
      addr_q <= addr_q + stride_q;
    end
  end

  assign rd_data_o = mem[addr_q];

  p_stride_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i) |=> addr_q == AW'($past(addr_q) + $past(stride_q)));

endmodule

// File: rtl/tcache_ctrl.sv
module tcache_ctrl
  import tcache_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int DEPTH      = 256,
  parameter int RAM_DEPTH  = 256,
  parameter int DW         = 16,
  localparam int IW  = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int LW  = $clog2(DEPTH + 1),
  localparam int RW  = $clog2(RAM_DEPTH),
  localparam int RLW = $clog2(RAM_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           is_trav_i,
  input  logic           go_i,
  input  logic           inval_i,
  input  logic [IW-1:0]  trav_id_i,
  output logic           need_assist_o,
  output logic           done_o,
  output logic           overflow_o,
  input  logic           ram_we_i,
  input  logic [RW-1:0]  ram_waddr_i,
  input  logic [DW-1:0]  ram_wdata_i,
  input  logic [RW-1:0]  arr_base_i,
  input  logic [RW-1:0]  arr_stride_i,
  input  logic [RLW-1:0] arr_len_i,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [DW-1:0]  in_data_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [DW-1:0]  out_data_o
);

  tc_state_e state_q;
  logic [IW-1:0]  cur_id_q;
  logic [LW-1:0]  ptr_q;
  logic [RLW-1:0] acnt_q, alen_q;
  logic           poison_q, done_q, ovf_q;

  logic [NUM_CACHES-1:0]         valid_vec;
  logic [NUM_CACHES-1:0][LW-1:0] len_vec;
  logic [IW-1:0] sel_id;
  logic          sel_valid;
  logic [LW-1:0] sel_len;
  logic [DW-1:0] store_rd, ram_rd;
  logic acc, room, out_fire, last_rep, last_arr, inv_hit;
  logic wr_en, commit, arr_start, arr_step;

  assign sel_id    = (state_q == ST_IDLE) ? trav_id_i : cur_id_q;
  assign sel_valid = valid_vec[sel_id];
  assign sel_len   = len_vec[sel_id];

  assign in_ready_o = (state_q == ST_ASSIST) && is_trav_i && out_ready_i;
  assign acc        = in_valid_i && in_ready_o;
  assign room       = ptr_q < LW'(DEPTH);
  assign inv_hit    = inval_i && (trav_id_i == cur_id_q);

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = '0;
    unique case (state_q)
      ST_ASSIST: begin
        out_valid_o = in_valid_i && is_trav_i;
        out_data_o  = in_data_i;
      end
      ST_REPLAY: begin
        out_valid_o = 1'b1;
        out_data_o  = store_rd;
      end
      ST_ARRAY: begin
        out_valid_o = 1'b1;
        out_data_o  = ram_rd;
      end
      default: ;
    endcase
  end

  assign out_fire  = out_valid_o && out_ready_i;
  assign last_rep  = ptr_q == sel_len - LW'(1);
  assign last_arr  = acnt_q == alen_q - RLW'(1);
  assign wr_en     = (state_q == ST_ASSIST) && acc && room;
  assign commit    = (state_q == ST_ASSIST) && !is_trav_i && !ovf_q && !poison_q && !inv_hit;
  assign arr_start = (state_q == ST_IDLE) && go_i && !is_trav_i;
  assign arr_step  = (state_q == ST_ARRAY) && out_fire;

  assign need_assist_o = ((state_q == ST_IDLE) && is_trav_i && !sel_valid) ||
                         (state_q == ST_ASSIST);
  assign done_o     = done_q;
  assign overflow_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cur_id_q <= '0;
      ptr_q    <= '0;
      acnt_q   <= '0;
      alen_q   <= '0;
      poison_q <= 1'b0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          done_q   <= 1'b0;
          ovf_q    <= 1'b0;
          poison_q <= 1'b0;
          ptr_q    <= '0;
          acnt_q   <= '0;
          cur_id_q <= trav_id_i;
          alen_q   <= arr_len_i;
          if (is_trav_i) begin
            if (!sel_valid)          state_q <= ST_ASSIST;
            else if (sel_len == '0)  done_q  <= 1'b1;
            else                     state_q <= ST_REPLAY;
          end else begin
            if (arr_len_i == '0) done_q  <= 1'b1;
            else                 state_q <= ST_ARRAY;
          end
        end
        ST_ASSIST: begin
          if (acc) begin
            if (room) ptr_q <= ptr_q + LW'(1);
            else      ovf_q <= 1'b1;
          end
          if (inv_hit) poison_q <= 1'b1;
          if (!is_trav_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_REPLAY: if (out_fire) begin
          ptr_q <= ptr_q + LW'(1);
          if (last_rep) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_ARRAY: if (out_fire) begin
          acnt_q <= acnt_q + RLW'(1);
          if (last_arr) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tcache_store #(.N(NUM_CACHES), .DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_id_i      (cur_id_q),
    .wr_addr_i    (ptr_q[AW-1:0]),
    .wr_data_i    (in_data_i),
    .commit_i     (commit),
    .commit_id_i  (cur_id_q),
    .commit_len_i (ptr_q),
    .inv_i        (inval_i),
    .inv_id_i     (trav_id_i),
    .rd_id_i      (sel_id),
    .rd_addr_i    (ptr_q[AW-1:0]),
    .rd_data_o    (store_rd),
    .valid_o      (valid_vec),
    .len_o        (len_vec)
  );

  tcache_array #(.DEPTH(RAM_DEPTH), .DW(DW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ram_we_i),
    .waddr_i   (ram_waddr_i),
    .wdata_i   (ram_wdata_i),
    .start_i   (arr_start),
    .base_i    (arr_base_i),
    .stride_i  (arr_stride_i),
    .step_i    (arr_step),
    .rd_data_o (ram_rd)
  );

  p_assist_not_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASSIST) |-> !done_o);

  p_hold_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && state_q != ST_ASSIST)
    |=> (out_valid_o && $stable(out_data_o)));

  p_replay_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REPLAY) |-> (ptr_q < sel_len));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASSIST && !is_trav_i && ovf_q) |=> !valid_vec[$past(cur_id_q)]);

  p_poison_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASSIST && !is_trav_i && poison_q) |=> !valid_vec[$past(cur_id_q)]);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE));

  p_ready_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (out_ready_i && need_assist_o));

endmodule

// File: tb/tcache_ctrl_tb.sv
`timescale 1ns/1ps
module tcache_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        is_trav = 0, go = 0, inval = 0;
  logic [1:0]  trav_id = 0;
  logic        need_assist, done, overflow;
  logic        ram_we = 0;
  logic [7:0]  ram_waddr = 0;
  logic [15:0] ram_wdata = 0;
  logic [7:0]  arr_base = 0, arr_stride = 0;
  logic [8:0]  arr_len = 0;
  logic        in_valid = 0, in_ready;
  logic [15:0] in_data = 0;
  logic        out_valid, out_ready = 0;
  logic [15:0] out_data;

  tcache_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .is_trav_i(is_trav), .go_i(go), .inval_i(inval), .trav_id_i(trav_id),
    .need_assist_o(need_assist), .done_o(done), .overflow_o(overflow),
    .ram_we_i(ram_we), .ram_waddr_i(ram_waddr), .ram_wdata_i(ram_wdata),
    .arr_base_i(arr_base), .arr_stride_i(arr_stride), .arr_len_i(arr_len),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] em [4][256];
  int          exp_len [4];
  bit          exp_val [4];
  logic [15:0] ram_m [256];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] arr_addr(int base, int stride, int k);
    return 8'((base + k * stride) % 256);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic probe_assist(int id, bit exp);
    @(negedge clk);
    is_trav = 1; trav_id = 2'(id);
    #1 check("R1 need_assist probe", 32'(need_assist), 32'(exp));
    @(negedge clk);
    is_trav = 0;
  endtask

  task automatic do_assist(int id, int n, int pct, bit inv_mid);
    logic [15:0] wq [320];
    int k;
    for (int i = 0; i < n; i++) wq[i] = 16'($urandom);
    @(negedge clk);
    is_trav = 1; trav_id = 2'(id);
    #1 check("R1 need_assist on miss", 32'(need_assist), 32'd1);
    @(negedge clk);
    go = 1;
    @(negedge clk);
    go = 0;
    k = 0;
    while (k < n) begin
      in_valid  = ($urandom % 4) != 0;
      in_data   = wq[k];
      out_ready = ($urandom % 100) < 32'(pct);
      inval     = inv_mid && (k == n / 2);
      #1;
      if (!out_ready) check("R2 in_ready follows out_ready", 32'(in_ready), 32'd0);
      check("R1 need_assist during assist", 32'(need_assist), 32'd1);
      if (in_valid && in_ready) begin
        check("R2 pass valid", 32'(out_valid), 32'd1);
        check("R2 pass data", 32'(out_data), 32'(wq[k]));
        k++;
      end
      @(negedge clk);
    end
    in_valid = 0; inval = 0; is_trav = 0;
    @(negedge clk);
    #1;
    check("R3 done after stream end", 32'(done), 32'd1);
    check("R9 overflow flag", 32'(overflow), 32'(n > 256));
    for (int i = 0; i < n && i < 256; i++) em[id][i] = wq[i];
    exp_val[id] = (n <= 256) && !inv_mid;
    exp_len[id] = n;
  endtask

  task automatic do_replay(int id, int pct);
    int k, cyc;
    bit held;
    logic [15:0] hv;
    @(negedge clk);
    is_trav = 1; trav_id = 2'(id);
    #1 check("R1 need_assist on hit", 32'(need_assist), 32'd0);
    @(negedge clk);
    go = 1;
    @(negedge clk);
    go = 0; is_trav = 0;
    k = 0; cyc = 0; held = 0; hv = '0;
    for (int t = 0; t < 4000; t++) begin
      out_ready = ($urandom % 100) < 32'(pct);
      #1;
      if (done) break;
      cyc++;
      if (held) check("R5 replay hold", 32'(out_data), 32'(hv));
      if (out_valid && out_ready) begin
        check("R4 replay word", 32'(out_data), 32'(em[id][k]));
        k++; held = 0;
      end else if (out_valid) begin
        held = 1; hv = out_data;
      end
      @(negedge clk);
    end
    check("R4 replay count", 32'(k), 32'(exp_len[id]));
    if (pct == 100) check("R4 one word per cycle", 32'(cyc), 32'(exp_len[id]));
    check("R4 idle after done", 32'(out_valid), 32'd0);
    out_ready = 0;
  endtask

  task automatic do_array(int base, int stride, int len, int pct);
    int k;
    bit held;
    logic [15:0] hv;
    @(negedge clk);
    is_trav = 0;
    arr_base = 8'(base); arr_stride = 8'(stride); arr_len = 9'(len);
    go = 1;
    @(negedge clk);
    go = 0;
    k = 0; held = 0; hv = '0;
    for (int t = 0; t < 4000; t++) begin
      out_ready = ($urandom % 100) < 32'(pct);
      #1;
      if (done) break;
      if (held) check("R5 array hold", 32'(out_data), 32'(hv));
      if (out_valid && out_ready) begin
        check("R6 array word", 32'(out_data), 32'(ram_m[arr_addr(base, stride, k)]));
        k++; held = 0;
      end else if (out_valid) begin
        held = 1; hv = out_data;
      end
      @(negedge clk);
    end
    check("R6 array count", 32'(k), 32'(len));
    out_ready = 0;
  endtask

  task automatic do_inval(int id);
    @(negedge clk);
    is_trav = 0; trav_id = 2'(id); inval = 1;
    @(negedge clk);
    inval = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4; i++) begin exp_len[i] = 0; exp_val[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check("R12 done after reset", 32'(done), 32'd0);
    check("R12 overflow after reset", 32'(overflow), 32'd0);
    check("R12 out_valid after reset", 32'(out_valid), 32'd0);
    check("R12 in_ready after reset", 32'(in_ready), 32'd0);
    for (int i = 0; i < 4; i++) probe_assist(i, 1'b1);

    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ram_we = 1; ram_waddr = 8'(a); ram_wdata = 16'($urandom);
      ram_m[a] = ram_wdata;
    end
    @(negedge clk);
    ram_we = 0;

    // R3 capture then R4 replay
    do_assist(0, 40, 70, 0);
    do_replay(0, 100);
    do_replay(0, 50);

    // exactly DEPTH words fits
    do_assist(1, 256, 100, 0);
    do_replay(1, 100);
    do_replay(0, 80);   // R8 untouched by id 1

    // R7 invalidate id 0, R8 id 1 still valid
    do_inval(0);
    probe_assist(0, 1'b1);
    probe_assist(1, 1'b0);
    do_replay(1, 60);

    // R9 overflow
    do_assist(3, 300, 90, 0);
    probe_assist(3, 1'b1);

    // R10 invalidate during capture
    do_assist(2, 20, 80, 1);
    probe_assist(2, 1'b1);

    // R11 zero-length recording and replay
    do_assist(2, 0, 100, 0);
    probe_assist(2, 1'b0);
    do_replay(2, 100);

    // R7 recapture after invalidate
    do_assist(0, 17, 100, 0);
    do_replay(0, 40);

    // R6 array mode patterns
    do_array(5, 3, 50, 60);
    do_array(250, 1, 20, 100);
    do_array(9, 0, 4, 50);
    do_array(0, 255, 8, 100);
    repeat (3) @(negedge clk);
    #1 check("R11 done sticky", 32'(done), 32'd1);
    do_array(0, 1, 0, 100);
    check("R11 zero-length array no output", 32'(out_valid), 32'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule